// File: doc/BRIEF.md
# Configuration-Phase Clock and Reset Controller

This block sits between the clock input pins and the core during configuration loading. It watches a configuration-done level, `cfg_done`, which is low while a download is in progress. A 32-bit control word decides which of eight global clocks and four fast clocks are stopped during that window. It also decides whether the core set/reset net is held asserted and whether all user outputs are forced to high impedance. When configuration finishes, every hold lifts together. A stopped clock is always parked high, and each gate changes state only at a rising edge of the clock it gates.

The configuration state is tracked in a free-running system clock domain. `cfg_done` is treated as synchronous to `sys_clk`. The rising edge of `cfg_done` is detected against a registered copy of it. Each clock gate brings the request into its own clock domain through a short synchronizer. The gate then ORs the final stage onto the clock, so the output is already high at the instant the gate engages or lets go. The control word is a plain input, and no register access is provided here.

Control word layout, which the surrounding logic depends on:
- Bits 16..23 and 24..27 are the clock disables.
- Bit 28 is reserved.
- Bit 29 is ignored.
- Bit 30 is the set/reset hold.
- Bit 31 is the tri-state force.
- Bits 0..15 carry nothing for this block.

Top module: `cfg_clkrst_ctrl`

## Requirements
- R1: Control bit 16+i (i = 0..7) governs global clock i. When the bit is 1 and `cfg_done` is low, `gclk_out[i]` is stopped. When the bit is 0, or `cfg_done` is high, `gclk_out[i]` equals `gclk_in[i]`.
- R2: Control bit 24+j (j = 0..3) governs fast clock j with the same encoding as R1, acting on `fclk_out[j]`.
- R3: A stopped clock output reads 1 continuously for as long as it is stopped.
- R4: A gated output never reads 0 while its input reads 1. Gates engage and release only on the rising edge of their own input clock, after a `SYNC_STAGES`-edge synchronizer.
- R5: A disable bit affects only its own clock. All other clock outputs keep following their inputs.
- R6: When `cfg_done` is low at a `sys_clk` rising edge, `core_srst_n` is driven to the inverse of control bit 30 one `sys_clk` cycle later. With bit 30 at 0, `core_srst_n` stays 1.
- R7: When `cfg_done` is low at a `sys_clk` rising edge, `io_tri_force` is driven to control bit 31 one `sys_clk` cycle later.
- R8: On the rising edge of `cfg_done`, both holds and all clock gates are released: `core_srst_n` is 1 and `io_tri_force` is 0 one cycle later. They stay released while `cfg_done` is high, whatever the control word holds.
- R9: Control bit 28 at 1 sets `rsv_err` one `sys_clk` cycle later. `rsv_err` then stays 1 until reset, and bit 28 has no other effect. Control bit 29 has no effect on any output.
- R10: While `sys_rst_n` is low, and right after it is released with `cfg_done` high: `core_srst_n` is 1, `io_tri_force` is 0, `rsv_err` is 0, and every clock output follows its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock for configuration tracking |
| sys_rst_n | input | 1 | Asynchronous active-low reset for all domains |
| cfg_done | input | 1 | High when configuration download is complete, low while it runs |
| ctrl_word | input | 32 | Configuration control word |
| gclk_in | input | 8 | Global clock inputs |
| fclk_in | input | 4 | Fast clock inputs |
| gclk_out | output | 8 | Gated global clocks, parked high when stopped |
| fclk_out | output | 4 | Gated fast clocks, parked high when stopped |
| core_srst_n | output | 1 | Active-low core set/reset hold |
| io_tri_force | output | 1 | Forces all user outputs to high impedance when high |
| rsv_err | output | 1 | Sticky flag: reserved control bit seen at 1 |

## Verification
A wrong hold or edge-detect state in the system domain appears at `core_srst_n` or `io_tri_force` one `sys_clk` cycle after the input that should have set or cleared it. The bench model is compared on every cycle, so such an error is caught on that cycle. A stuck or misrouted synchronizer in a clock gate shows as an output that pulses low while stopped, or stays high while enabled. It becomes visible within `SYNC_STAGES` periods of that input clock. The bench therefore samples every gated clock at sub-period steps over a window several periods long. A sticky flag that clears itself shows as `rsv_err` dropping after the reserved bit is withdrawn.

// File: rtl/cfg_clkrst_pkg.sv
`timescale 1ns/1ps
package cfg_clkrst_pkg;

    localparam int CTRL_W   = 32;
    localparam int GCLK_LSB = 16;   // bit 16+i gates global clock i
    localparam int FCLK_LSB = 24;   // bit 24+j gates fast clock j
    localparam int RSV_BIT  = 28;   // must be zero; a 1 raises the sticky flag
    localparam int SRST_BIT = 30;   // hold core set/reset during download
    localparam int TRI_BIT  = 31;   // force user outputs to high impedance

    typedef struct packed {
        logic done_q;     // registered copy of cfg_done for edge detection
        logic cfg_act;    // configuration download in progress
        logic srst_hold;  // set/reset net held asserted
        logic tri_hold;   // user outputs forced to high impedance
        logic rsv_err;    // sticky reserved-bit error
    } seq_state_t;

endpackage

// File: rtl/cfg_phase_seq.sv
`timescale 1ns/1ps
module cfg_phase_seq
    import cfg_clkrst_pkg::*;
(
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic cfg_done,
    input  logic srst_en,
    input  logic tri_en,
    input  logic rsv_bit,
    output logic cfg_active,
    output logic srst_hold,
    output logic tri_hold,
    output logic rsv_err
);

    seq_state_t st_d, st_q;
    logic       done_rise;

    always_comb begin
        st_d        = st_q;
        done_rise   = cfg_done & ~st_q.done_q;
        st_d.done_q = cfg_done;

        if (done_rise) begin
            // End of download: every configuration-time hold lifts together.
            st_d.cfg_act   = 1'b0;
            st_d.srst_hold = 1'b0;
            st_d.tri_hold  = 1'b0;
        end else if (!cfg_done) begin
            // Download running: holds follow their enable bits.
            st_d.cfg_act   = 1'b1;
            st_d.srst_hold = srst_en;
            st_d.tri_hold  = tri_en;
        end

        st_d.rsv_err = st_q.rsv_err | rsv_bit;
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q <= '{done_q: 1'b1, cfg_act: 1'b0, srst_hold: 1'b0,
                      tri_hold: 1'b0, rsv_err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_active = st_q.cfg_act;
    assign srst_hold  = st_q.srst_hold;
    assign tri_hold   = st_q.tri_hold;
    assign rsv_err    = st_q.rsv_err;

endmodule

// File: rtl/clk_gate_park.sv
`timescale 1ns/1ps
module clk_gate_park #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic dis_req,
    output logic clk_out
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = dis_req;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            sync_d[k] = sync_q[k-1];
        end
    end

    // Every stage updates on the rising edge of the gated clock itself.
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // The last stage only moves while clk_in is high, so the OR never glitches.
    assign clk_out = clk_in | sync_q[LAST];

endmodule

// File: rtl/cfg_clkrst_ctrl.sv
`timescale 1ns/1ps
module cfg_clkrst_ctrl
    import cfg_clkrst_pkg::*;
#(
    parameter int NUM_GCLK    = 8,
    parameter int NUM_FCLK    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                sys_clk,
    input  logic                sys_rst_n,
    input  logic                cfg_done,
    input  logic [CTRL_W-1:0]   ctrl_word,
    input  logic [NUM_GCLK-1:0] gclk_in,
    input  logic [NUM_FCLK-1:0] fclk_in,
    output logic [NUM_GCLK-1:0] gclk_out,
    output logic [NUM_FCLK-1:0] fclk_out,
    output logic                core_srst_n,
    output logic                io_tri_force,
    output logic                rsv_err
);

    logic cfg_active;
    logic srst_hold;
    logic tri_hold;
    logic ctrl_unused;

    // Bits 0..15 and 29 carry nothing for this block.
    assign ctrl_unused = ^ctrl_word;

    cfg_phase_seq u_seq (
        .sys_clk    (sys_clk),
        .sys_rst_n  (sys_rst_n),
        .cfg_done   (cfg_done),
        .srst_en    (ctrl_word[SRST_BIT]),
        .tri_en     (ctrl_word[TRI_BIT]),
        .rsv_bit    (ctrl_word[RSV_BIT]),
        .cfg_active (cfg_active),
        .srst_hold  (srst_hold),
        .tri_hold   (tri_hold),
        .rsv_err    (rsv_err)
    );

    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_gclk
        clk_gate_park #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_in  (gclk_in[g]),
            .rst_n   (sys_rst_n),
            .dis_req (cfg_active & ctrl_word[GCLK_LSB+g]),
            .clk_out (gclk_out[g])
        );
    end

    for (genvar f = 0; f < NUM_FCLK; f++) begin : g_fclk
        clk_gate_park #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_in  (fclk_in[f]),
            .rst_n   (sys_rst_n),
            .dis_req (cfg_active & ctrl_word[FCLK_LSB+f]),
            .clk_out (fclk_out[f])
        );
    end

    assign core_srst_n  = ~srst_hold;
    assign io_tri_force = tri_hold;

endmodule

// File: rtl/cfg_clkrst_ctrl_chk.sv
`timescale 1ns/1ps
module cfg_clkrst_ctrl_chk
    import cfg_clkrst_pkg::*;
(
    input logic              sys_clk,
    input logic              sys_rst_n,
    input logic              cfg_done,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic              core_srst_n,
    input logic              io_tri_force,
    input logic              rsv_err
);

    AST_SRST_HELD: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (!cfg_done && ctrl_word[SRST_BIT]) |=> !core_srst_n); // R6

    AST_SRST_NORMAL: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (!cfg_done && !ctrl_word[SRST_BIT]) |=> core_srst_n); // R6

    AST_TRI_FORCED: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (!cfg_done && ctrl_word[TRI_BIT]) |=> io_tri_force); // R7

    AST_RELEASED_WHEN_DONE: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        cfg_done |=> (core_srst_n && !io_tri_force)); // R8

    AST_RSV_FLAGGED: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ctrl_word[RSV_BIT] |=> rsv_err); // R9

    AST_RSV_STICKY: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        rsv_err |=> rsv_err); // R9

endmodule

bind cfg_clkrst_ctrl cfg_clkrst_ctrl_chk u_chk (
    .sys_clk      (sys_clk),
    .sys_rst_n    (sys_rst_n),
    .cfg_done     (cfg_done),
    .ctrl_word    (ctrl_word),
    .core_srst_n  (core_srst_n),
    .io_tri_force (io_tri_force),
    .rsv_err      (rsv_err)
);

// File: tb/cfg_clkrst_ctrl_tb.sv
`timescale 1ns/100ps
module cfg_clkrst_ctrl_tb_top;

    logic        sys_clk = 1'b0;
    logic        sys_rst_n;
    logic        cfg_done;
    logic [31:0] ctrl_word;
    logic [7:0]  gclk_in;
    logic [3:0]  fclk_in;
    logic [7:0]  gclk_out;
    logic [3:0]  fclk_out;
    logic        core_srst_n;
    logic        io_tri_force;
    logic        rsv_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference model state (behavioural)
    int m_prev_done;
    int m_srst;
    int m_tri;
    int m_err;

    always #4 sys_clk = ~sys_clk;   // 125 MHz

    for (genvar g = 0; g < 8; g++) begin : g_gck
        initial begin
            gclk_in[g] = 1'b0;
            #(1 + g);
            forever #(3 + g) gclk_in[g] = ~gclk_in[g];
        end
    end
    for (genvar f = 0; f < 4; f++) begin : g_fck
        initial begin
            fclk_in[f] = 1'b0;
            #(2 + f);
            forever #(5 + f) fclk_in[f] = ~fclk_in[f];
        end
    end

    cfg_clkrst_ctrl dut_i (
        .sys_clk      (sys_clk),
        .sys_rst_n    (sys_rst_n),
        .cfg_done     (cfg_done),
        .ctrl_word    (ctrl_word),
        .gclk_in      (gclk_in),
        .fclk_in      (fclk_in),
        .gclk_out     (gclk_out),
        .fclk_out     (fclk_out),
        .core_srst_n  (core_srst_n),
        .io_tri_force (io_tri_force),
        .rsv_err      (rsv_err)
    );

    function automatic logic [31:0] mk(input bit tri_b, input bit srst_b, input bit b29,
                                       input bit b28, input logic [3:0] fm, input logic [7:0] gm);
        return {tri_b, srst_b, b29, b28, fm, gm, 16'h0000};
    endfunction

    // Model update on every system clock edge
    always @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            m_prev_done = 1; m_srst = 0; m_tri = 0; m_err = 0;
        end else begin
            if (cfg_done && !m_prev_done) begin
                m_srst = 0; m_tri = 0;
            end else if (!cfg_done) begin
                m_srst = ctrl_word[30] ? 1 : 0;
                m_tri  = ctrl_word[31] ? 1 : 0;
            end
            if (ctrl_word[28]) m_err = 1;
            m_prev_done = cfg_done ? 1 : 0;
        end
    end

    // Comparison on every clock, away from the active edge
    always @(negedge sys_clk) begin
        if (sys_rst_n && !finished) begin
            n_checks++;
            if (core_srst_n !== (m_srst == 0)) begin
                n_fail++;
                $display("FAIL R6 R8 core_srst_n actual=%0b expected=%0b t=%0t",
                         core_srst_n, (m_srst == 0), $time);
            end
            n_checks++;
            if (io_tri_force !== (m_tri != 0)) begin
                n_fail++;
                $display("FAIL R7 R8 io_tri_force actual=%0b expected=%0b t=%0t",
                         io_tri_force, (m_tri != 0), $time);
            end
            n_checks++;
            if (rsv_err !== (m_err != 0)) begin
                n_fail++;
                $display("FAIL R9 rsv_err actual=%0b expected=%0b t=%0t",
                         rsv_err, (m_err != 0), $time);
            end
        end
    end

    // Watch every gated clock over a window; stopped ones must read 1, others follow input.
    task automatic check_gates(input logic [7:0] gm, input logic [3:0] fm, input string tag);
        bit [7:0] gbad = '0;
        bit [3:0] fbad = '0;
        logic [7:0] g_act = '0, g_exp = '0;
        logic [3:0] f_act = '0, f_exp = '0;
        repeat (160) begin
            #1;
            for (int i = 0; i < 8; i++) begin
                if (!gbad[i] && gclk_out[i] !== (gm[i] ? 1'b1 : gclk_in[i])) begin
                    gbad[i] = 1; g_act[i] = gclk_out[i]; g_exp[i] = gm[i] ? 1'b1 : gclk_in[i];
                end
            end
            for (int j = 0; j < 4; j++) begin
                if (!fbad[j] && fclk_out[j] !== (fm[j] ? 1'b1 : fclk_in[j])) begin
                    fbad[j] = 1; f_act[j] = fclk_out[j]; f_exp[j] = fm[j] ? 1'b1 : fclk_in[j];
                end
            end
        end
        for (int i = 0; i < 8; i++) begin
            n_checks++;
            if (gbad[i]) begin
                n_fail++;
                $display("FAIL R1 R3 R4 R5 %s gclk_out[%0d] actual=%0b expected=%0b",
                         tag, i, g_act[i], g_exp[i]);
            end
        end
        for (int j = 0; j < 4; j++) begin
            n_checks++;
            if (fbad[j]) begin
                n_fail++;
                $display("FAIL R2 R3 R4 R5 %s fclk_out[%0d] actual=%0b expected=%0b",
                         tag, j, f_act[j], f_exp[j]);
            end
        end
    endtask

    task automatic apply(input logic done_v, input logic [31:0] cw);
        @(negedge sys_clk);
        cfg_done  = done_v;
        ctrl_word = cw;
        repeat (10) @(negedge sys_clk);
        #0.5;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        sys_rst_n = 1'b0;
        cfg_done  = 1'b1;
        ctrl_word = '0;
        repeat (5) @(negedge sys_clk);
        #0.5;
        // R10: reset state while reset is held
        n_checks++;
        if (core_srst_n !== 1'b1 || io_tri_force !== 1'b0 || rsv_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset outputs actual=%0b%0b%0b expected=100",
                     core_srst_n, io_tri_force, rsv_err);
        end
        check_gates(8'h00, 4'h0, "R10 in-reset");
        @(negedge sys_clk);
        sys_rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);
        #0.5;
        n_checks++;
        if (core_srst_n !== 1'b1 || io_tri_force !== 1'b0 || rsv_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 post-reset outputs actual=%0b%0b%0b expected=100",
                     core_srst_n, io_tri_force, rsv_err);
        end
        check_gates(8'h00, 4'h0, "R10 post-reset");

        // Download with a mixed pattern, both holds on
        apply(1'b0, mk(1, 1, 0, 0, 4'h3, 8'hA5));
        n_checks++;
        if (core_srst_n !== 1'b0 || io_tri_force !== 1'b1) begin
            n_fail++;
            $display("FAIL R6 R7 holds actual=%0b%0b expected=01", core_srst_n, io_tri_force);
        end
        check_gates(8'hA5, 4'h3, "R1 R2 pattern A5/3");

        // Done rises: everything released
        apply(1'b1, mk(1, 1, 0, 0, 4'h3, 8'hA5));
        n_checks++;
        if (core_srst_n !== 1'b1 || io_tri_force !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 release actual=%0b%0b expected=10", core_srst_n, io_tri_force);
        end
        check_gates(8'h00, 4'h0, "R8 released");

        // Done high: a full control word has no effect
        apply(1'b1, mk(1, 1, 0, 0, 4'hF, 8'hFF));
        check_gates(8'h00, 4'h0, "R8 done-high all bits");

        // Complementary pattern, set/reset hold only, ignored bit 29 set
        apply(1'b0, mk(0, 1, 1, 0, 4'hC, 8'h5A));
        n_checks++;
        if (core_srst_n !== 1'b0 || io_tri_force !== 1'b0) begin
            n_fail++;
            $display("FAIL R6 R7 R9 holds actual=%0b%0b expected=00", core_srst_n, io_tri_force);
        end
        check_gates(8'h5A, 4'hC, "R1 R2 R9 pattern 5A/C");

        // Single-bit isolation
        apply(1'b0, mk(0, 0, 0, 0, 4'h0, 8'h80));
        check_gates(8'h80, 4'h0, "R5 only gclk7");
        apply(1'b0, mk(0, 0, 0, 0, 4'h1, 8'h00));
        check_gates(8'h00, 4'h1, "R5 only fclk0");

        // Bit 29 alone: no effect anywhere
        apply(1'b0, mk(0, 0, 1, 0, 4'h0, 8'h00));
        n_checks++;
        if (core_srst_n !== 1'b1 || io_tri_force !== 1'b0 || rsv_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 bit29 actual=%0b%0b%0b expected=100",
                     core_srst_n, io_tri_force, rsv_err);
        end
        check_gates(8'h00, 4'h0, "R9 bit29 ignored");

        // Reserved bit: sticky flag, no other effect
        apply(1'b0, mk(0, 0, 0, 1, 4'h0, 8'h00));
        check_gates(8'h00, 4'h0, "R9 bit28 no gating");
        apply(1'b1, mk(0, 0, 0, 0, 4'h0, 8'h00));
        n_checks++;
        if (rsv_err !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 sticky rsv_err actual=%0b expected=1", rsv_err);
        end

        finish_run();
    end

endmodule